// File: doc/BRIEF.md
# Flash Command Sequencer

This block decodes the host-side command protocol of a byte-wide flash array and runs the write-state control behind it. The host issues write cycles, each an address and a data byte, through a single-cycle write enable. Some commands take one cycle and only change the read mode or the status flags. Others take two cycles: a setup byte, then a confirm or data byte. These start an erase, a program or a lock-bit operation on a small behavioural array that lives inside the block.

Each operation keeps the block busy for a fixed, parameterised number of clock cycles. The ready output and status bit 7 are low for that time. An erase or program in progress can be parked and later continued. Per-block lock bits and a master lock bit protect the array. A high-voltage-enable input overrides them. Refused operations and malformed sequences are reported through sticky error flags in the status byte. Reads go through `rdata`, whose source depends on the current read mode: array contents, identifier codes or the status byte.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, ready is 1, the read mode is array (every location reads FFh), and the status byte reads 80h.
- R2: FFh selects array reads, 70h selects status reads, and 90h selects identifier reads. In identifier mode, address bits [1:0] pick the code: 0 gives MFR_CODE (default 5Ah), 1 gives DEV_CODE (default C3h), 2 gives the lock bit of the block in the upper address bits (in bit 0), and 3 gives the master lock bit (in bit 0).
- R3: Status bits are: 7 ready, 6 erase parked, 5 erase error, 4 program error, 2 program parked, 1 protect error; bits 3 and 0 are 0. The error bits stay set until a 50h write clears all three.
- R4: 20h followed by D0h erases the block addressed by the second cycle to FFh. Ready is low from the edge that takes D0h for exactly ERASE_CYCLES cycles, and other blocks are untouched.
- R5: 40h or 10h followed by a data cycle programs the addressed byte to old AND data after PROG_CYCLES cycles, so program only clears bits.
- R6: B0h during a running erase or program parks it: ready returns to 1 on the next edge, bit 6 (erase) or bit 2 (program) is set, and the remaining cycle count is frozen. D0h continues the operation, which then finishes after exactly the cycles it had left.
- R7: After a 60h first cycle, 01h sets the lock bit of the addressed block, F1h sets the master lock bit, and D0h clears all block lock bits. Each of these takes LOCK_CYCLES cycles.
- R8: An erase or program aimed at a locked block with hv_en low is refused. The array is unchanged, ready stays 1, and bit 1 is set together with bit 5 (erase) or bit 4 (program). With hv_en high, the operation runs.
- R9: Setting the master lock bit needs hv_en high. While the master lock bit is set, setting or clearing block lock bits also needs hv_en high, and a refused change sets bit 1 only.
- R10: An unknown first byte, or a second byte that does not fit its setup byte, sets bits 5 and 4, changes neither the array nor the lock bits, and returns the decoder to expecting a first cycle.
- R11: A two-cycle setup byte, a refused sequence or a launched operation switches reads to the status byte.
- R12: While an operation runs and is not parked, only B0h and 70h take effect; any other write is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write cycle, sampled on the rising clock edge |
| addr | input | ADDR_W | Address for writes and reads |
| wdata | input | 8 | Command or program data byte |
| hv_en | input | 1 | High-voltage enable, overrides lock protection |
| rdata | output | 8 | Read data for the current read mode and address |
| ready | output | 1 | High when no operation runs or the running one is parked |

## Verification
A write is captured on the rising edge after the bench drives it. Read-mode changes and refusals show on `rdata` right after that edge, because reads are combinational from the registered state. An operation of N cycles drops ready on the capture edge, keeps it low after edges 1 to N-1, and raises it after edge N, when the array change becomes visible. The bench drives inputs on the falling edge and samples on the falling edge. It checks ready at exactly N-1 and N cycles after the capturing edge. For parked operations it subtracts the running edges already spent, counting the edge that took B0h as one of them.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    typedef enum logic [1:0] {
        RD_ARRAY  = 2'd0,
        RD_IDENT  = 2'd1,
        RD_STATUS = 2'd2
    } rd_mode_e;

    typedef enum logic [1:0] {
        PEND_NONE,
        PEND_ERASE,
        PEND_PROG,
        PEND_LOCK
    } pend_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_ERASE,
        OP_PROG,
        OP_LOCK_SET,
        OP_MASTER_SET,
        OP_LOCK_CLR
    } op_kind_e;

    typedef struct packed {
        op_kind_e   kind;
        logic [7:0] data;
    } op_req_t;

    typedef struct packed {
        logic erase_err;
        logic prog_err;
        logic protect;
    } err_flags_t;

    localparam logic [7:0] CMD_ARRAY     = 8'hFF;
    localparam logic [7:0] CMD_IDENT     = 8'h90;
    localparam logic [7:0] CMD_STATUS    = 8'h70;
    localparam logic [7:0] CMD_CLEAR     = 8'h50;
    localparam logic [7:0] CMD_ERASE     = 8'h20;
    localparam logic [7:0] CMD_PROG_A    = 8'h40;
    localparam logic [7:0] CMD_PROG_B    = 8'h10;
    localparam logic [7:0] CMD_LOCK      = 8'h60;
    localparam logic [7:0] CMD_PARK      = 8'hB0;
    localparam logic [7:0] CMD_CONFIRM   = 8'hD0;
    localparam logic [7:0] SUB_BLOCK_LK  = 8'h01;
    localparam logic [7:0] SUB_MASTER_LK = 8'hF1;

    function automatic logic [7:0] pack_status(logic rdy, logic e_park, logic p_park,
                                               err_flags_t e);
        return {rdy, e_park, e.erase_err, e.prog_err, 1'b0, p_park, e.protect, 1'b0};
    endfunction

    function automatic logic can_park(op_kind_e k);
        return (k == OP_ERASE) || (k == OP_PROG);
    endfunction

endpackage

// File: rtl/fcs_decoder.sv
module fcs_decoder
    import fcs_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              busy,
    input  logic              parked,
    output rd_mode_e          rd_mode,
    output op_req_t           req,
    output logic [ADDR_W-1:0] req_addr,
    output logic              seq_err,
    output logic              park_req,
    output logic              resume_req,
    output logic              clr_req
);

    pend_e    pend_q, pend_d;
    rd_mode_e mode_d;

    assign req_addr = addr;

    always_comb begin
        pend_d     = pend_q;
        mode_d     = rd_mode;
        req        = '{kind: OP_NONE, data: wdata};
        seq_err    = 1'b0;
        park_req   = 1'b0;
        resume_req = 1'b0;
        clr_req    = 1'b0;
        if (wr_en) begin
            if (pend_q != PEND_NONE) begin
                pend_d = PEND_NONE;
                mode_d = RD_STATUS;
                case (pend_q)
                    PEND_ERASE: begin
                        if (wdata == CMD_CONFIRM) req.kind = OP_ERASE;
                        else                      seq_err  = 1'b1;
                    end
                    PEND_PROG: req.kind = OP_PROG;
                    default: begin
                        case (wdata)
                            SUB_BLOCK_LK:  req.kind = OP_LOCK_SET;
                            SUB_MASTER_LK: req.kind = OP_MASTER_SET;
                            CMD_CONFIRM:   req.kind = OP_LOCK_CLR;
                            default:       seq_err  = 1'b1;
                        endcase
                    end
                endcase
            end else if (busy && !parked) begin
                if (wdata == CMD_PARK)        park_req = 1'b1;
                else if (wdata == CMD_STATUS) mode_d   = RD_STATUS;
            end else if (parked) begin
                case (wdata)
                    CMD_ARRAY:   mode_d = RD_ARRAY;
                    CMD_STATUS:  mode_d = RD_STATUS;
                    CMD_IDENT:   mode_d = RD_IDENT;
                    CMD_CONFIRM: begin
                        resume_req = 1'b1;
                        mode_d     = RD_STATUS;
                    end
                    default: ;
                endcase
            end else begin
                case (wdata)
                    CMD_ARRAY:  mode_d = RD_ARRAY;
                    CMD_IDENT:  mode_d = RD_IDENT;
                    CMD_STATUS: mode_d = RD_STATUS;
                    CMD_CLEAR:  clr_req = 1'b1;
                    CMD_ERASE: begin
                        pend_d = PEND_ERASE;
                        mode_d = RD_STATUS;
                    end
                    CMD_PROG_A, CMD_PROG_B: begin
                        pend_d = PEND_PROG;
                        mode_d = RD_STATUS;
                    end
                    CMD_LOCK: begin
                        pend_d = PEND_LOCK;
                        mode_d = RD_STATUS;
                    end
                    CMD_PARK, CMD_CONFIRM: ;
                    default: begin
                        seq_err = 1'b1;
                        mode_d  = RD_STATUS;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= PEND_NONE;
            rd_mode <= RD_ARRAY;
        end else begin
            pend_q  <= pend_d;
            rd_mode <= mode_d;
        end
    end

    // R12
    pend_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q != PEND_NONE) |-> (!busy && !parked));

endmodule

// File: rtl/fcs_guard.sv
module fcs_guard
    import fcs_pkg::*;
#(
    parameter int NUM_BLOCKS = 4,
    parameter int BLK_W      = 2
) (
    input  op_kind_e              kind,
    input  logic [BLK_W-1:0]      blk,
    input  logic [NUM_BLOCKS-1:0] lock_bits,
    input  logic                  master,
    input  logic                  hv_en,
    output logic                  allow
);

    always_comb begin
        case (kind)
            OP_ERASE, OP_PROG:       allow = !lock_bits[blk] || hv_en;
            OP_LOCK_SET, OP_LOCK_CLR: allow = !master || hv_en;
            OP_MASTER_SET:           allow = hv_en;
            default:                 allow = 1'b1;
        endcase
    end

endmodule

// File: rtl/fcs_engine.sv
module fcs_engine
    import fcs_pkg::*;
#(
    parameter int ADDR_W       = 6,
    parameter int ERASE_CYCLES = 12,
    parameter int PROG_CYCLES  = 4,
    parameter int LOCK_CYCLES  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  op_req_t           req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              allow,
    input  logic              seq_err,
    input  logic              park_req,
    input  logic              resume_req,
    input  logic              clr_req,
    output logic              busy,
    output logic              parked,
    output logic [7:0]        status,
    output op_req_t           commit,
    output logic [ADDR_W-1:0] commit_addr
);

    localparam int MAX_A  = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
    localparam int MAX_C  = (MAX_A > LOCK_CYCLES) ? MAX_A : LOCK_CYCLES;
    localparam int CNT_W  = $clog2(MAX_C + 1);

    function automatic logic [CNT_W-1:0] load_of(op_kind_e k);
        case (k)
            OP_ERASE: return CNT_W'(ERASE_CYCLES - 1);
            OP_PROG:  return CNT_W'(PROG_CYCLES - 1);
            default:  return CNT_W'(LOCK_CYCLES - 1);
        endcase
    endfunction

    logic              busy_q, park_q;
    logic [CNT_W-1:0]  cnt_q;
    op_req_t           cur_q;
    logic [ADDR_W-1:0] cur_addr_q;
    err_flags_t        err_q;
    logic              done;

    assign done        = busy_q && !park_q && (cnt_q == '0);
    assign commit      = '{kind: done ? cur_q.kind : OP_NONE, data: cur_q.data};
    assign commit_addr = cur_addr_q;
    assign busy        = busy_q;
    assign parked      = park_q;
    assign status      = pack_status(!busy_q || park_q,
                                     park_q && (cur_q.kind == OP_ERASE),
                                     park_q && (cur_q.kind == OP_PROG),
                                     err_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q     <= 1'b0;
            park_q     <= 1'b0;
            cnt_q      <= '0;
            cur_q      <= '{kind: OP_NONE, data: 8'h00};
            cur_addr_q <= '0;
            err_q      <= '0;
        end else begin
            if (busy_q && !park_q) begin
                if (done) begin
                    busy_q <= 1'b0;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                    if (park_req && can_park(cur_q.kind)) park_q <= 1'b1;
                end
            end
            if (park_q && resume_req) park_q <= 1'b0;
            if (req.kind != OP_NONE) begin
                if (allow) begin
                    busy_q     <= 1'b1;
                    cur_q      <= req;
                    cur_addr_q <= req_addr;
                    cnt_q      <= load_of(req.kind);
                end else begin
                    err_q.protect <= 1'b1;
                    if (req.kind == OP_ERASE) err_q.erase_err <= 1'b1;
                    if (req.kind == OP_PROG)  err_q.prog_err  <= 1'b1;
                end
            end
            if (seq_err) begin
                err_q.erase_err <= 1'b1;
                err_q.prog_err  <= 1'b1;
            end
            if (clr_req) err_q <= '0;
        end
    end

    // R4
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (req.kind != OP_NONE && allow) |=> busy_q);

    // R8
    deny_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (req.kind != OP_NONE && !allow && !busy_q) |=> (!busy_q && err_q.protect));

    // R6
    park_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        park_q |=> $stable(cnt_q));

    // R3
    protect_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err_q.protect && !clr_req) |=> err_q.protect);

endmodule

// File: rtl/fcs_array.sv
module fcs_array
    import fcs_pkg::*;
#(
    parameter int NUM_BLOCKS  = 4,
    parameter int BLOCK_BYTES = 16,
    parameter int ADDR_W      = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  op_req_t               commit,
    input  logic [ADDR_W-1:0]     commit_addr,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [7:0]            rd_byte,
    output logic [NUM_BLOCKS-1:0] lock_bits,
    output logic                  master
);

    localparam int DEPTH = NUM_BLOCKS * BLOCK_BYTES;
    localparam int OFF_W = $clog2(BLOCK_BYTES);
    localparam int BLK_W = ADDR_W - OFF_W;

    logic [DEPTH*8-1:0]    flat;
    logic [BLK_W-1:0]      cblk;
    logic [NUM_BLOCKS-1:0] lock_q;
    logic                  master_q;

    assign cblk      = commit_addr[ADDR_W-1 -: BLK_W];
    assign rd_byte   = flat[{rd_addr, 3'b000} +: 8];
    assign lock_bits = lock_q;
    assign master    = master_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(g);
        localparam logic [BLK_W-1:0]  MY_BLK  = BLK_W'(g / BLOCK_BYTES);
        logic [7:0] cell_q;

        always_ff @(posedge clk) begin
            if (rst)
                cell_q <= 8'hFF;
            else if (commit.kind == OP_ERASE && cblk == MY_BLK)
                cell_q <= 8'hFF;
            else if (commit.kind == OP_PROG && commit_addr == MY_ADDR)
                cell_q <= cell_q & commit.data;
        end

        assign flat[g*8 +: 8] = cell_q;

        // R5
        prog_clears_chk: assert property (@(posedge clk) disable iff (rst)
            (commit.kind == OP_PROG) |=> ((cell_q & ~$past(cell_q)) == 8'h00));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q   <= '0;
            master_q <= 1'b0;
        end else begin
            case (commit.kind)
                OP_LOCK_SET:   lock_q[cblk] <= 1'b1;
                OP_LOCK_CLR:   lock_q       <= '0;
                OP_MASTER_SET: master_q     <= 1'b1;
                default: ;
            endcase
        end
    end

    // R9
    master_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        master_q |=> master_q);

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int          NUM_BLOCKS   = 4,
    parameter int          BLOCK_BYTES  = 16,
    parameter int          ERASE_CYCLES = 12,
    parameter int          PROG_CYCLES  = 4,
    parameter int          LOCK_CYCLES  = 6,
    parameter logic [7:0]  MFR_CODE     = 8'h5A,
    parameter logic [7:0]  DEV_CODE     = 8'hC3,
    parameter int          ADDR_W       = $clog2(NUM_BLOCKS * BLOCK_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              hv_en,
    output logic [7:0]        rdata,
    output logic              ready
);

    localparam int BLK_W = $clog2(NUM_BLOCKS);

    rd_mode_e              rd_mode;
    op_req_t               req, commit;
    logic [ADDR_W-1:0]     req_addr, commit_addr;
    logic                  seq_err, park_req, resume_req, clr_req;
    logic                  busy, parked, allow, master;
    logic [7:0]            status, arr_byte;
    logic [NUM_BLOCKS-1:0] lock_bits;

    fcs_decoder #(.ADDR_W(ADDR_W)) u_dec (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .busy(busy), .parked(parked), .rd_mode(rd_mode), .req(req),
        .req_addr(req_addr), .seq_err(seq_err), .park_req(park_req),
        .resume_req(resume_req), .clr_req(clr_req)
    );

    fcs_guard #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W)) u_guard (
        .kind(req.kind), .blk(req_addr[ADDR_W-1 -: BLK_W]), .lock_bits(lock_bits),
        .master(master), .hv_en(hv_en), .allow(allow)
    );

    fcs_engine #(
        .ADDR_W(ADDR_W), .ERASE_CYCLES(ERASE_CYCLES),
        .PROG_CYCLES(PROG_CYCLES), .LOCK_CYCLES(LOCK_CYCLES)
    ) u_eng (
        .clk(clk), .rst(rst), .req(req), .req_addr(req_addr), .allow(allow),
        .seq_err(seq_err), .park_req(park_req), .resume_req(resume_req),
        .clr_req(clr_req), .busy(busy), .parked(parked), .status(status),
        .commit(commit), .commit_addr(commit_addr)
    );

    fcs_array #(
        .NUM_BLOCKS(NUM_BLOCKS), .BLOCK_BYTES(BLOCK_BYTES), .ADDR_W(ADDR_W)
    ) u_arr (
        .clk(clk), .rst(rst), .commit(commit), .commit_addr(commit_addr),
        .rd_addr(addr), .rd_byte(arr_byte), .lock_bits(lock_bits), .master(master)
    );

    assign ready = status[7];

    always_comb begin
        case (rd_mode)
            RD_STATUS: rdata = status;
            RD_IDENT: begin
                case (addr[1:0])
                    2'd0:    rdata = MFR_CODE;
                    2'd1:    rdata = DEV_CODE;
                    2'd2:    rdata = {7'b0, lock_bits[addr[ADDR_W-1 -: BLK_W]]};
                    default: rdata = {7'b0, master};
                endcase
            end
            default: rdata = arr_byte;
        endcase
    end

endmodule

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ERASE_N = 12;
    localparam int PROG_N  = 4;
    localparam int LOCK_N  = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [5:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       hv_en = 1'b0;
    logic [7:0] rdata;
    logic       ready;
    int         checks = 0;
    int         fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_seq #(
        .NUM_BLOCKS(4), .BLOCK_BYTES(16), .ERASE_CYCLES(ERASE_N),
        .PROG_CYCLES(PROG_N), .LOCK_CYCLES(LOCK_N)
    ) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .hv_en(hv_en), .rdata(rdata), .ready(ready)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(string tag, logic [5:0] a, logic [7:0] exp);
        addr = a;
        #1;
        chk(tag, rdata, exp);
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    // called right after the write that started the op; n edges of busy remain
    task automatic run_op(string tag, int n);
        chk(tag, {7'b0, ready}, 8'h00);
        wait_n(n - 1);
        chk(tag, {7'b0, ready}, 8'h00);
        wait_n(1);
        chk(tag, {7'b0, ready}, 8'h01);
    endtask

    task automatic t_reset();
        chk("R1 ready", {7'b0, ready}, 8'h01);
        rd_chk("R1 array", 6'd0, 8'hFF);
        rd_chk("R1 array", 6'd47, 8'hFF);
        wr(6'd0, 8'h70);
        rd_chk("R1 status", 6'd0, 8'h80);
    endtask

    task automatic t_ident();
        wr(6'd0, 8'h90);
        rd_chk("R2 mfr", 6'd0, 8'h5A);
        rd_chk("R2 dev", 6'd1, 8'hC3);
        rd_chk("R2 blklock", 6'd34, 8'h00);
        rd_chk("R2 master", 6'd3, 8'h00);
        wr(6'd0, 8'hFF);
        rd_chk("R2 back to array", 6'd0, 8'hFF);
    endtask

    task automatic t_program();
        wr(6'd0, 8'h40);
        rd_chk("R11 setup->status", 6'd9, 8'h80);
        wr(6'd2, 8'h55);
        rd_chk("R11 busy status", 6'd2, 8'h00);
        run_op("R5 prog time", PROG_N);
        rd_chk("R5 done status", 6'd2, 8'h80);
        wr(6'd0, 8'hFF);
        rd_chk("R5 prog data", 6'd2, 8'h55);
        wr(6'd0, 8'h10);
        wr(6'd2, 8'hF0);
        run_op("R5 alt setup", PROG_N);
        wr(6'd0, 8'hFF);
        rd_chk("R5 and-merge", 6'd2, 8'h50);
        wr(6'd0, 8'h40);
        wr(6'd18, 8'h3C);
        run_op("R5 prog blk1", PROG_N);
    endtask

    task automatic t_erase();
        wr(6'd0, 8'h20);
        wr(6'd20, 8'hD0);
        run_op("R4 erase time", ERASE_N);
        wr(6'd0, 8'hFF);
        rd_chk("R4 erased", 6'd18, 8'hFF);
        rd_chk("R4 other blk", 6'd2, 8'h50);
    endtask

    task automatic t_busy_ignore();
        wr(6'd0, 8'h20);
        wr(6'd16, 8'hD0);
        wait_n(2);
        wr(6'd2, 8'hFF);
        rd_chk("R12 FF ignored", 6'd2, 8'h00);
        run_op("R12 timing", ERASE_N - 3);
    endtask

    task automatic t_park();
        wr(6'd0, 8'h40);
        wr(6'd20, 8'h0F);
        run_op("R6 pre", PROG_N);
        wr(6'd0, 8'h20);
        wr(6'd16, 8'hD0);
        wait_n(3);
        wr(6'd0, 8'hB0);
        chk("R6 ready parked", {7'b0, ready}, 8'h01);
        rd_chk("R6 erase park status", 6'd0, 8'hC0);
        wr(6'd0, 8'hFF);
        rd_chk("R6 frozen data", 6'd20, 8'h0F);
        wait_n(10);
        chk("R6 still parked", {7'b0, ready}, 8'h01);
        wr(6'd0, 8'hD0);
        rd_chk("R6 resumed", 6'd0, 8'h00);
        run_op("R6 remaining", ERASE_N - 4);
        wr(6'd0, 8'hFF);
        rd_chk("R6 erase done", 6'd20, 8'hFF);
        wr(6'd0, 8'h40);
        wr(6'd40, 8'h11);
        wr(6'd0, 8'hB0);
        rd_chk("R6 prog park status", 6'd0, 8'h84);
        wr(6'd0, 8'hD0);
        run_op("R6 prog remaining", PROG_N - 1);
        wr(6'd0, 8'hFF);
        rd_chk("R6 prog done", 6'd40, 8'h11);
    endtask

    task automatic t_lock();
        wr(6'd32, 8'h60);
        wr(6'd32, 8'h01);
        run_op("R7 lock time", LOCK_N);
        wr(6'd0, 8'h90);
        rd_chk("R7 blk2 locked", 6'd34, 8'h01);
        wr(6'd0, 8'h40);
        wr(6'd33, 8'h00);
        chk("R8 refused ready", {7'b0, ready}, 8'h01);
        rd_chk("R8 prog refused", 6'd0, 8'h92);
        wr(6'd0, 8'hFF);
        rd_chk("R8 data kept", 6'd33, 8'hFF);
        wr(6'd0, 8'h50);
        wr(6'd0, 8'h70);
        rd_chk("R3 cleared", 6'd0, 8'h80);
        hv_en = 1'b1;
        wr(6'd0, 8'h40);
        wr(6'd33, 8'h00);
        run_op("R8 hv prog", PROG_N);
        hv_en = 1'b0;
        wr(6'd0, 8'hFF);
        rd_chk("R8 hv prog data", 6'd33, 8'h00);
        wr(6'd0, 8'h20);
        wr(6'd32, 8'hD0);
        rd_chk("R8 erase refused", 6'd0, 8'hA2);
        wr(6'd0, 8'h70);
        rd_chk("R3 sticky", 6'd0, 8'hA2);
        wr(6'd0, 8'h50);
        wr(6'd0, 8'h60);
        wr(6'd0, 8'hF1);
        rd_chk("R9 master needs hv", 6'd0, 8'h82);
        wr(6'd0, 8'h90);
        rd_chk("R9 master clear", 6'd3, 8'h00);
        wr(6'd0, 8'h50);
        hv_en = 1'b1;
        wr(6'd0, 8'h60);
        wr(6'd0, 8'hF1);
        run_op("R7 master time", LOCK_N);
        hv_en = 1'b0;
        wr(6'd0, 8'h90);
        rd_chk("R7 master set", 6'd3, 8'h01);
        wr(6'd0, 8'h60);
        wr(6'd0, 8'hD0);
        rd_chk("R9 clear refused", 6'd0, 8'h82);
        wr(6'd0, 8'h90);
        rd_chk("R9 lock kept", 6'd34, 8'h01);
        wr(6'd0, 8'h50);
        wr(6'd0, 8'h60);
        wr(6'd0, 8'h01);
        rd_chk("R9 set refused", 6'd0, 8'h82);
        wr(6'd0, 8'h90);
        rd_chk("R9 blk0 unlocked", 6'd2, 8'h00);
        wr(6'd0, 8'h50);
        hv_en = 1'b1;
        wr(6'd0, 8'h60);
        wr(6'd0, 8'hD0);
        run_op("R7 clear time", LOCK_N);
        hv_en = 1'b0;
        wr(6'd0, 8'h90);
        rd_chk("R7 all cleared", 6'd34, 8'h00);
        wr(6'd0, 8'h20);
        wr(6'd32, 8'hD0);
        run_op("R8 unlocked erase", ERASE_N);
        wr(6'd0, 8'hFF);
        rd_chk("R8 erased", 6'd33, 8'hFF);
    endtask

    task automatic t_seq();
        wr(6'd0, 8'h33);
        chk("R10 no op", {7'b0, ready}, 8'h01);
        rd_chk("R10 bad first", 6'd0, 8'hB0);
        wr(6'd0, 8'h50);
        rd_chk("R3 clear", 6'd0, 8'h80);
        wr(6'd0, 8'h60);
        wr(6'd0, 8'h77);
        rd_chk("R10 bad lock sub", 6'd0, 8'hB0);
        wr(6'd0, 8'h90);
        rd_chk("R10 lock unchanged", 6'd2, 8'h00);
        wr(6'd0, 8'h50);
        wr(6'd0, 8'h20);
        wr(6'd5, 8'h40);
        wr(6'd5, 8'h55);
        rd_chk("R10 back to first cycle", 6'd0, 8'hB0);
        wr(6'd0, 8'hFF);
        rd_chk("R10 data kept", 6'd5, 8'hFF);
        wr(6'd0, 8'h50);
        wr(6'd0, 8'h70);
        rd_chk("R3 final clear", 6'd0, 8'h80);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ident();
        t_program();
        t_erase();
        t_busy_ignore();
        t_park();
        t_lock();
        t_seq();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 8'h01, 8'h00);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule